// File: doc/BRIEF.md
# Five-Level Third-Order Noise Shaper

This block sits in a converter's playback path between an interpolation stage and a multi-level analog output stage. It takes signed 18-bit samples that arrive at eight times the audio sample rate and turns them into a stream of 5-level codes at 64 times the sample rate. The codes carry the signal in their running average and push the quantization error toward high frequencies. The block keeps each input word for eight modulator cycles, which is a zero-order hold. A loop of three cascaded delaying integrators then drives a symmetric five-level quantizer. The quantized level is fed back, scaled so that levels -2..+2 span the full input range.

The block runs on one clock at the modulator rate, which is 64 times the sample rate. The `take_o` strobe tells the upstream filter the cycle in which the next word is captured, so the upstream stage runs at one eighth of the clock. With a system clock of 512 times the sample rate, this clock is that system clock divided by eight. The interpolation ratio of 8 and the modulator ratio of 8 then give the overall oversampling of 64.

Top module: `dsm5_mod`

## Requirements
- R1: While reset is held and in the first cycle after its release, `code_o` is 2 and `take_o` is 1.
- R2: `take_o` is high for one cycle in every 8 clock cycles. Its first pulse is in the cycle right after reset is released.
- R3: `smp_i` is sampled only at the rising edge that ends a cycle with `take_o` high. The value on `smp_i` in any other cycle has no effect on `code_o`.
- R4: `code_o` is always in the range 0 to 4, where code k stands for feedback level k-2 times 2^16.
- R5: When the input is held at 0 from reset, `code_o` is 2 in every cycle.
- R6: For a constant input x with |x| ≤ 2^16, the sum of (code-2) over 2048 cycles, taken after a 256-cycle settle, equals 2048·x/2^16 to within ±16.
- R7: The quantizer rounds ties away from zero and is symmetric. With +2^16 held from reset, `code_o` is 2 after rising edges 1 to 4 and 3 after edge 5. With -2^16 it is 1 after edge 5.
- R8: The integrator states saturate at the signed 24-bit limits and never wrap from one sign to the other.
- R9: For a full-scale positive input (2^17-1), the mean code over 1024 cycles is at least 3.5. For full-scale negative input (-2^17), it is at most 0.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 18 | Signed input sample from the interpolator |
| take_o | output | 1 | High in the cycle whose closing edge captures `smp_i` |
| code_o | output | 3 | Five-level output code, 0 to 4 |

## Verification
The main function is exercised with a table of constant inputs: zero, ±1/4, ±1/2, ±3/4 and ±1 of the feedback step. The long-run code sum must match each input, which separates a correct loop gain and feedback scale from wrong shifts or a wrong sign. Full-scale inputs of both signs test the saturating edge of the quantizer range. A step of exactly one feedback unit lands the third integrator on a quantizer threshold at edge 5, which exposes a wrong tie rule or a wrong threshold. Two runs with the same held value, one of which toggles `smp_i` outside the capture cycle, must produce identical code streams. That comparison shows the hold ignores the non-capture cycles.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;
  localparam int NSTG = 3;

  typedef logic [2:0] code_t;

  // right shift applied to the previous integrator before it enters stage g
  function automatic int stg_shift(int g);
    case (g)
      1:       return 2;
      2:       return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dsm5_hold.sv
module dsm5_hold #(
  parameter int IN_W = 18,
  parameter int HOLD = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] smp_i,
  output logic                   take_o,
  output logic signed [IN_W-1:0] hold_o
);
  localparam int PW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HOLD - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign take_o = (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (take_o) hold_o <= smp_i;
  end

  // R3: held word changes only at a capture edge
  a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> $stable(hold_o));

  // R2: strobe is a single-cycle pulse
  a_r2_take_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
endmodule

// File: rtl/dsm5_integ.sv
module dsm5_integ #(
  parameter int W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W:0]   add_i,
  output logic signed [W-1:0] acc_o
);
  localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

  logic signed [W+1:0] sum;

  assign sum = $signed({{2{acc_o[W-1]}}, acc_o}) + $signed({add_i[W], add_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_o <= '0;
    else if (sum > MAXV)  acc_o <= MAXV[W-1:0];
    else if (sum < MINV)  acc_o <= MINV[W-1:0];
    else                  acc_o <= sum[W-1:0];
  end

  // R8: near either limit the state never jumps to the opposite sign
  a_r8_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o[W-1 -: 3] == 3'b011) |=> !acc_o[W-1]);
  a_r8_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o[W-1 -: 3] == 3'b100) |=> acc_o[W-1]);
endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant #(
  parameter int W       = 24,
  parameter int STEP_LG = 16
) (
  input  logic signed [W-1:0] acc_i,
  output dsm5_pkg::code_t     code_o,
  output logic signed [W:0]   fb_o
);
  localparam logic signed [W-1:0] T_LO = W'(1) <<< (STEP_LG - 1);
  localparam logic signed [W-1:0] T_HI = W'(3) <<< (STEP_LG - 1);

  logic signed [2:0] lvl;

  always_comb begin
    if (acc_i >= T_HI)       lvl = 3'sd2;
    else if (acc_i >= T_LO)  lvl = 3'sd1;
    else if (acc_i > -T_LO)  lvl = 3'sd0;
    else if (acc_i > -T_HI)  lvl = -3'sd1;
    else                     lvl = -3'sd2;
  end

  assign code_o = 3'(lvl + 3'sd2);
  assign fb_o   = (W+1)'(lvl) <<< STEP_LG;
endmodule

// File: rtl/dsm5_mod.sv
module dsm5_mod #(
  parameter int IN_W  = 18,
  parameter int ACC_W = 24,
  parameter int HOLD  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] smp_i,
  output logic                   take_o,
  output logic [2:0]             code_o
);
  import dsm5_pkg::*;

  localparam int STEP_LG = IN_W - 2;

  logic signed [IN_W-1:0]  hold;
  logic signed [ACC_W:0]   fb;
  logic signed [ACC_W-1:0] acc [NSTG];
  logic signed [ACC_W:0]   add [NSTG];
  code_t                   code;

  dsm5_hold #(.IN_W(IN_W), .HOLD(HOLD)) i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_i),
    .take_o(take_o),
    .hold_o(hold)
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    if (g == 0) begin : g_in
      assign add[g] = $signed({{(ACC_W + 1 - IN_W){hold[IN_W-1]}}, hold}) - fb;
    end else begin : g_chain
      localparam int SH = stg_shift(g);
      logic signed [ACC_W-1:0] scl;
      assign scl    = acc[g-1] >>> SH;
      assign add[g] = $signed({scl[ACC_W-1], scl}) - fb;
    end

    dsm5_integ #(.W(ACC_W)) i_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .add_i (add[g]),
      .acc_o (acc[g])
    );
  end

  dsm5_quant #(.W(ACC_W), .STEP_LG(STEP_LG)) i_quant (
    .acc_i (acc[NSTG-1]),
    .code_o(code),
    .fb_o  (fb)
  );

  assign code_o = code;

  // R4: five legal codes only
  a_r4_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= 3'd4);

  // R5: an all-zero loop with zero held input stays idle at mid code
  a_r5_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold == '0 && acc[0] == '0 && acc[1] == '0 && acc[2] == '0) |=> code_o == 3'd2);
endmodule

// File: tb/test_dsm5_mod.sv
module test_dsm5_mod;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [17:0] smp = '0;
  logic               take;
  logic [2:0]         code;

  int total = 0;
  int bad   = 0;

  localparam int NVEC = 9;
  localparam int VEC_X [NVEC] = '{0, 16384, -16384, 32768, -32768, 49152, -49152, 65536, -65536};
  localparam int SETTLE = 256;
  localparam int NWIN   = 2048;

  dsm5_mod i_dsm5_mod (
    .clk_i (clk),
    .rst_ni(rst_n),
    .smp_i (smp),
    .take_o(take),
    .code_o(code)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset held over posedges; released at a negedge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [2:0] rec_a [64];

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint s;

    // R6: DC table walked by one loop (R5 is the zero entry)
    for (int v = 0; v < NVEC; v++) begin
      smp = 18'(VEC_X[v]);
      do_reset();
      repeat (SETTLE) @(negedge clk);
      s = 0;
      for (int k = 0; k < NWIN; k++) begin
        @(negedge clk);
        s += longint'(code) - 2;
      end
      chk((s * 65536 - longint'(NWIN) * VEC_X[v]) <= 16 * 65536 &&
          (longint'(NWIN) * VEC_X[v] - s * 65536) <= 16 * 65536,
          "R6 dc sum", s, longint'(NWIN) * VEC_X[v] / 65536);
    end

    // R1: reset state
    smp = 18'sd12345;
    rst_n = 1'b0;
    @(negedge clk);
    chk(code == 3'd2, "R1 code in reset", code, 2);
    rst_n = 1'b1;
    chk(code == 3'd2, "R1 code after release", code, 2);
    chk(take == 1'b1, "R1 take after release", take, 1);

    // R2: strobe period
    begin
      int miss = 0;
      for (int k = 1; k < 64; k++) begin
        @(negedge clk);
        if (take != ((k % 8) == 0)) miss++;
      end
      chk(miss == 0, "R2 take period", miss, 0);
    end

    // R5: zero input gives code 2 every cycle
    begin
      int off = 0;
      smp = '0;
      do_reset();
      for (int k = 0; k < 512; k++) begin
        @(negedge clk);
        if (code != 3'd2) off++;
      end
      chk(off == 0, "R5 idle code", off, 0);
    end

    // R7: threshold tie at +step lands on edge 5
    smp = 18'sd65536;
    do_reset();
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk);
      chk(code == ((e == 5) ? 3'd3 : 3'd2), "R7 pos step", code, (e == 5) ? 3 : 2);
    end
    smp = -18'sd65536;
    do_reset();
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk);
      chk(code == ((e == 5) ? 3'd1 : 3'd2), "R7 neg step", code, (e == 5) ? 1 : 2);
    end

    // R3: off-capture input changes are ignored
    smp = 18'sd40000;
    do_reset();
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      rec_a[k] = code;
    end
    smp = 18'sd40000;
    do_reset();
    begin
      int diff = 0;
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        if (code != rec_a[k]) diff++;
        smp = take ? 18'sd40000 : ((k % 2) ? -18'sd131072 : 18'sd131071);
      end
      chk(diff == 0, "R3 off-phase ignored", diff, 0);
    end

    // R9 and R4: full scale both signs, codes stay legal
    begin
      int hi = 0;
      smp = 18'sd131071;
      do_reset();
      repeat (SETTLE) @(negedge clk);
      s = 0;
      for (int k = 0; k < 1024; k++) begin
        @(negedge clk);
        s += code;
        if (code > 3'd4) hi++;
      end
      chk(s >= 3584, "R9 full-scale positive mean", s, 3584);
      chk(hi == 0, "R4 code range positive", hi, 0);
      hi = 0;
      smp = -18'sd131072;
      do_reset();
      repeat (SETTLE) @(negedge clk);
      s = 0;
      for (int k = 0; k < 1024; k++) begin
        @(negedge clk);
        s += code;
        if (code > 3'd4) hi++;
      end
      chk(s <= 512, "R9 full-scale negative mean", s, 512);
      chk(hi == 0, "R4 code range negative", hi, 0);
    end

    // R8: long full-scale run holds integrators; checked by a_r8 assertions, observed here as sane codes
    smp = 18'sd131071;
    repeat (4096) @(negedge clk);
    chk(code <= 3'd4 && code >= 3'd2, "R8 saturated run code", code, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule